// File: doc/BRIEF.md
# Half-Bridge Gate Controller with Dead Time

This block turns per-phase PWM commands into gate enables for the upper and lower transistors of a set of half bridges. Each phase has one "top" command and one "bottom" command. The controller decodes each pair into a drive request: drive the output high, drive it low, or leave it floating. It never lets both transistors of a phase conduct together. Whenever one transistor hands over to the other, a programmable dead interval with both transistors off comes first.

Several global shutdown sources feed a single kill path: two independent disable inputs, a current-limit trip, and one undervoltage flag per supply. The kill path has one register stage less than the command path. It masks the gates directly, so shutdown never waits for the dead-time counter. All asynchronous inputs pass through a synchronizer with a parameterized number of stages. The controller raises no indication of why the outputs are off.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While reset is high, and in the first cycles after it, every upper and lower gate enable is low, whatever the commands are.
- R2: For any phase, the upper and lower gate enables are never high in the same cycle.
- R3: The command pair for a phase is decoded as top=1,bottom=0 → upper gate on; top=0,bottom=1 → lower gate on; top=0,bottom=0 or top=1,bottom=1 → both gates off (output floating). Each phase decodes only its own pair.
- R4: From a steady floating state, a new drive request reaches the gate enable on the (SYNC_STAGES+1)-th rising edge after the command changes. This is the 3rd edge with the defaults.
- R5: When the command of the active transistor is withdrawn, its gate enable drops on the (SYNC_STAGES+1)-th rising edge.
- R6: A direct swap (top and bottom commands exchanged at once) leaves both gates of that phase off for exactly DEAD_CYC+1 cycles before the other gate turns on. This is 5 cycles with the defaults.
- R7: A high level on either disable input, on the current-limit trip, or on any supply undervoltage flag drives all gates of all phases low on the SYNC_STAGES-th rising edge. This is one edge earlier than the command path.
- R8: A disable pulse lasting a single cycle keeps a previously active gate off for exactly DEAD_CYC+2 cycles. After that the gate returns while its command persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_top | input | NUM_PHASES | Per-phase upper-transistor command (asynchronous) |
| cmd_bot | input | NUM_PHASES | Per-phase lower-transistor command (asynchronous) |
| dis_a | input | 1 | First global disable, active high |
| dis_b | input | 1 | Second global disable, active high |
| ilim_trip | input | 1 | Current-limit trip, active high |
| uv_flag | input | NUM_SUPPLY | Per-supply undervoltage flag, active high |
| gate_hi | output | NUM_PHASES | Upper transistor gate enable per phase |
| gate_lo | output | NUM_PHASES | Lower transistor gate enable per phase |

## Verification
The hardest case to reach is a disable shorter than the dead interval that lands while a transistor is conducting. The gate must then stay off for the full recount, and must not come back the moment the kill clears. The bench drives a one-cycle pulse on a disable input while a phase is steadily high and counts the off cycles edge by edge. It also measures the swap gap between two settled, opposite drive states, so the dead counter starts from a known value.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int HB_NUM_SUPPLY = 2;

    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_LOW  = 2'd1,
        DRV_HIGH = 2'd2
    } drv_e;

    typedef struct packed {
        logic                     dis_a;
        logic                     dis_b;
        logic                     ilim;
        logic [HB_NUM_SUPPLY-1:0] uv;
    } kill_src_t;

    localparam int KILL_W = $bits(kill_src_t);

    // Both commands high is a request for "both off", as is neither.
    function automatic drv_e hb_decode(input logic top, input logic bot);
        drv_e r;
        case ({top, bot})
            2'b10:   r = DRV_HIGH;
            2'b01:   r = DRV_LOW;
            default: r = DRV_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_kill.sv
module hb_kill
    import hb_pkg::*;
(
    input  kill_src_t src,
    output logic      kill
);
    // Any source alone is sufficient; no source is reported separately.
    assign kill = src.dis_a | src.dis_b | src.ilim | (|src.uv);
endmodule

// File: rtl/hb_phase.sv
module hb_phase
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_top,
    input  logic req_bot,
    input  logic kill,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int CNT_W = $clog2(DEAD_CYC + 2);
    localparam logic [CNT_W-1:0] DEAD_V = CNT_W'(DEAD_CYC);
    localparam logic [CNT_W-1:0] GAP_V  = CNT_W'(DEAD_CYC + 1);

    drv_e             req;
    drv_e             cur_q, cur_d;
    logic [CNT_W-1:0] off_q, off_d;

    assign req = hb_decode(req_top, req_bot);

    always_comb begin
        cur_d = cur_q;
        if (cur_q != DRV_OFF) begin
            if (kill || req != cur_q) cur_d = DRV_OFF;
        end else if (!kill && req != DRV_OFF && off_q >= DEAD_V) begin
            cur_d = req;
        end
    end

    always_comb begin
        if (cur_q != DRV_OFF)   off_d = '0;
        else if (off_q < DEAD_V) off_d = off_q + 1'b1;
        else                     off_d = off_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= DRV_OFF;
            off_q <= '0;
        end else begin
            cur_q <= cur_d;
            off_q <= off_d;
        end
    end

    // Kill masks the gates directly, bypassing the dead-time state.
    assign gate_hi = (cur_q == DRV_HIGH) && !kill;
    assign gate_lo = (cur_q == DRV_LOW)  && !kill;

    // Checker: consecutive cycles with both gates low, saturating.
    logic [CNT_W-1:0] off_run;
    always_ff @(posedge clk) begin
        if (rst)                   off_run <= '0;
        else if (gate_hi || gate_lo) off_run <= '0;
        else if (off_run < GAP_V)  off_run <= off_run + 1'b1;
    end

    a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    a_r6_dead_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi || gate_lo) |-> off_run >= GAP_V);

    a_r3_float_req: assert property (@(posedge clk) disable iff (rst)
        (req == DRV_OFF) |=> (!gate_hi && !gate_lo));

    a_r7_kill_drops_state: assert property (@(posedge clk) disable iff (rst)
        kill |=> (cur_q == DRV_OFF));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int NUM_PHASES  = 2,
    parameter int NUM_SUPPLY  = HB_NUM_SUPPLY,
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYC    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PHASES-1:0] cmd_top,
    input  logic [NUM_PHASES-1:0] cmd_bot,
    input  logic                  dis_a,
    input  logic                  dis_b,
    input  logic                  ilim_trip,
    input  logic [NUM_SUPPLY-1:0] uv_flag,
    output logic [NUM_PHASES-1:0] gate_hi,
    output logic [NUM_PHASES-1:0] gate_lo
);
    localparam int CMD_W = 2 * NUM_PHASES;

    logic [CMD_W-1:0]  cmd_s;
    logic [KILL_W-1:0] kill_raw, kill_s;
    kill_src_t         src;
    logic              kill;

    assign kill_raw = {dis_a, dis_b, ilim_trip, HB_NUM_SUPPLY'(uv_flag)};

    hb_sync #(.WIDTH(CMD_W), .STAGES(SYNC_STAGES)) u_cmd_sync (
        .clk(clk), .rst(rst), .d({cmd_top, cmd_bot}), .q(cmd_s)
    );

    hb_sync #(.WIDTH(KILL_W), .STAGES(SYNC_STAGES)) u_kill_sync (
        .clk(clk), .rst(rst), .d(kill_raw), .q(kill_s)
    );

    assign src = kill_src_t'(kill_s);

    hb_kill u_kill (.src(src), .kill(kill));

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        hb_phase #(.DEAD_CYC(DEAD_CYC)) u_phase (
            .clk     (clk),
            .rst     (rst),
            .req_top (cmd_s[NUM_PHASES + p]),
            .req_bot (cmd_s[p]),
            .kill    (kill),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p])
        );
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/hb_gate_ctrl_tb.sv
module hb_gate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 2;
    localparam int DEAD = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] cmd_top, cmd_bot;
    logic          dis_a, dis_b, ilim_trip;
    logic [1:0]    uv_flag;
    logic [NP-1:0] gate_hi, gate_lo;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_gate_ctrl #(.NUM_PHASES(NP), .NUM_SUPPLY(2), .SYNC_STAGES(2), .DEAD_CYC(DEAD)) u_dut (
        .clk(clk), .rst(rst), .cmd_top(cmd_top), .cmd_bot(cmd_bot),
        .dis_a(dis_a), .dis_b(dis_b), .ilim_trip(ilim_trip), .uv_flag(uv_flag),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // {top[1:0], bot[1:0], expected hi[1:0], expected lo[1:0]}
    localparam logic [7:0] VEC [8] = '{
        8'b01_00_01_00, 8'b00_01_00_01, 8'b10_01_10_01, 8'b01_10_01_10,
        8'b11_11_00_00, 8'b11_00_11_00, 8'b00_11_00_11, 8'b01_11_00_10
    };

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] gates();
        return {gate_hi, gate_lo};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1; cmd_top = 2'b11; cmd_bot = 2'b00;
        dis_a = 0; dis_b = 0; ilim_trip = 0; uv_flag = 2'b00;
        tick(4);
        check("R1 in reset", gates(), 4'b0000);
        rst = 0;
        tick(1);
        check("R1 after reset", gates(), 4'b0000);
        cmd_top = 2'b00;
        tick(12);

        // R3 decode table
        foreach (VEC[i]) begin
            cmd_top = VEC[i][7:6];
            cmd_bot = VEC[i][5:4];
            tick(14);
            check($sformatf("R3 vector %0d", i), gates(), VEC[i][3:0]);
            check("R2 exclusive", {2'b00, gate_hi & gate_lo}, 4'b0000);
        end

        // R4 latency from steady float
        cmd_top = 2'b00; cmd_bot = 2'b00;
        tick(12);
        cmd_top = 2'b01;
        tick(2);
        check("R4 not yet on", gates(), 4'b0000);
        tick(1);
        check("R4 on at edge 3", gates(), 4'b0100);

        // R5 turn-off latency
        tick(5);
        cmd_top = 2'b00;
        tick(2);
        check("R5 still on", gates(), 4'b0100);
        tick(1);
        check("R5 off at edge 3", gates(), 4'b0000);

        // R6 direct swap high -> low on phase 0
        cmd_top = 2'b01; cmd_bot = 2'b00;
        tick(12);
        cmd_top = 2'b00; cmd_bot = 2'b01;
        tick(2);
        check("R6 high held", gates(), 4'b0100);
        tick(1);
        check("R6 gap start", gates(), 4'b0000);
        for (int k = 0; k < DEAD; k++) begin
            tick(1);
            check("R6 gap both off", gates(), 4'b0000);
        end
        tick(1);
        check("R6 low after gap", gates(), 4'b0001);

        // R7 each disable source
        for (int s = 0; s < 5; s++) begin
            cmd_top = 2'b01; cmd_bot = 2'b10;
            tick(14);
            check("R7 pre", gates(), 4'b0110);
            case (s)
                0: dis_a = 1;
                1: dis_b = 1;
                2: ilim_trip = 1;
                3: uv_flag = 2'b01;
                default: uv_flag = 2'b10;
            endcase
            tick(1);
            check($sformatf("R7 src %0d edge 1", s), gates(), 4'b0110);
            tick(1);
            check($sformatf("R7 src %0d all off", s), gates(), 4'b0000);
            tick(6);
            check($sformatf("R7 src %0d held off", s), gates(), 4'b0000);
            dis_a = 0; dis_b = 0; ilim_trip = 0; uv_flag = 2'b00;
        end

        // R8 single-cycle disable pulse with phase 0 high
        cmd_top = 2'b01; cmd_bot = 2'b00;
        tick(14);
        check("R8 pre", gates(), 4'b0100);
        dis_a = 1;
        tick(1);
        dis_a = 0;
        tick(1);
        check("R8 off", gates(), 4'b0000);
        for (int k = 0; k < DEAD + 1; k++) begin
            tick(1);
            check("R8 held off", gates(), 4'b0000);
        end
        tick(1);
        check("R8 returns", gates(), 4'b0100);

        finish_run();
    end
endmodule